// File: doc/BRIEF.md
# Internal Data Memory and Address Decoder

This block is the data-memory front end of an 8-bit microcontroller core. It holds 256 bytes of RAM and turns each core request into a RAM location or a cycle on an external special-function-register (SFR) bus. The request's access kind decides where it goes: direct addressing, indirect addressing, working-register addressing (relative to a selectable bank) or single-bit addressing.

The upper half of the address space is shared. A direct access there reaches the SFR bus. An indirect access there reaches the upper 128 bytes of RAM. Bit accesses cover a 16-byte RAM window and the SFRs whose address is a multiple of eight. A bit write is a read-modify-write: the target byte is read in the request cycle, and in the following cycle the block writes it back with one bit replaced. During that second cycle `busy` is high and new requests are not accepted. Reads answer one cycle after the request with `rsp_valid`.

Top module: `idata_unit`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid`, `busy` and `sfr_we` are 0 until a request is accepted.
- R2: A direct read or write (req_kind 0 = read, 1 = write) with address 0x00..0x7F accesses the RAM byte at that address. Read data appears on `rsp_data` with `rsp_valid` high in the cycle after the request.
- R3: A direct access to address 0x80..0xFF drives the SFR bus and leaves RAM untouched. A write raises `sfr_we` in the request cycle, with `sfr_addr` equal to the address and `sfr_wdata` equal to the write data. A read returns `sfr_rdata`, sampled in the request cycle, one cycle later.
- R4: An indirect access (req_kind 2 = read, 3 = write) reaches the RAM byte at any address 0x00..0xFF, including 0x80..0xFF, and never raises `sfr_we`.
- R5: A register access (req_kind 4 = read, 5 = write) reaches RAM address bank_sel*8 + req_addr[2:0]. req_addr[7:3] is ignored.
- R6: A bit access (req_kind 6 = read, 7 = write) with bit address 0x00..0x7F targets bit (addr & 7) of RAM byte 0x20 + (addr >> 3). A bit read returns the bit in rsp_data[0], with rsp_data[7:1] zero.
- R7: A bit access with bit address 0x80..0xFF targets bit (addr & 7) of the SFR at (addr & 0xF8). Every SFR write made by a bit write has sfr_addr[2:0] = 0.
- R8: A bit write changes only the selected bit, with the other seven bits unchanged. `busy` is high for exactly the one cycle after the request, and the write-back happens in that cycle (`sfr_we` with the merged byte for an SFR target).
- R9: A request presented while `busy` is high is ignored: it writes nothing and produces no response.
- R10: Write requests never raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind (encoding in R2..R6) |
| req_addr | input | 8 | Byte, register or bit address |
| req_wdata | input | 8 | Byte write data |
| req_bit | input | 1 | Value for a bit write |
| bank_sel | input | 2 | Working-register bank |
| busy | output | 1 | Second cycle of a bit write; requests ignored |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data (bit reads in bit 0) |
| sfr_addr | output | 8 | SFR bus address |
| sfr_we | output | 1 | SFR bus write strobe |
| sfr_wdata | output | 8 | SFR bus write data |
| sfr_rdata | input | 8 | SFR bus read data, sampled in the request cycle |

## Verification
The hardest case to reach is a bit write whose write-back collides with a new request. The merged byte goes out in the busy cycle while the core is already presenting its next access, so the bench issues a byte write to an unrelated location during that cycle and then reads both places back. Bit writes to an SFR are also preceded by loading distinct patterns into the seven neighbouring SFRs. This shows that the mapping to a multiple of eight never touches a neighbour and that the other seven bits of the target survive the merge.

// File: rtl/idata_pkg.sv
package idata_pkg;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned IW = $clog2(DW);

  // access kind encoding: bit 0 = write, bits 2:1 = addressing group
  typedef enum logic [2:0] {
    K_DIR_RD = 3'd0,
    K_DIR_WR = 3'd1,
    K_IND_RD = 3'd2,
    K_IND_WR = 3'd3,
    K_REG_RD = 3'd4,
    K_REG_WR = 3'd5,
    K_BIT_RD = 3'd6,
    K_BIT_WR = 3'd7
  } acc_kind_e;

  localparam logic [1:0] G_DIRECT   = 2'b00;
  localparam logic [1:0] G_INDIRECT = 2'b01;
  localparam logic [1:0] G_REGISTER = 2'b10;
  localparam logic [1:0] G_BIT      = 2'b11;

  typedef struct packed {
    logic          to_sfr;
    logic          is_bit;
    logic          is_wr;
    logic [AW-1:0] loc;
    logic [IW-1:0] idx;
  } target_t;

endpackage

// File: rtl/idata_decode.sv
module idata_decode
  import idata_pkg::*;
#(
  parameter int unsigned BANK_W = 2
) (
  input  logic [2:0]      kind,
  input  logic [AW-1:0]   addr,
  input  logic [BANK_W-1:0] bank,
  output target_t         tgt
);
  localparam int unsigned REG_W   = 3;
  localparam int unsigned HI_BIT  = AW - 1;
  localparam int unsigned WIN_W   = AW - 1 - IW;
  localparam logic [AW-1:0] BIT_WIN_BASE = AW'(8'h20);

  always_comb begin
    tgt        = '0;
    tgt.is_wr  = kind[0];
    tgt.idx    = addr[IW-1:0];
    unique case (kind[2:1])
      G_DIRECT: begin
        tgt.to_sfr = addr[HI_BIT];
        tgt.loc    = addr;
      end
      G_INDIRECT: begin
        tgt.to_sfr = 1'b0;
        tgt.loc    = addr;
      end
      G_REGISTER: begin
        tgt.to_sfr = 1'b0;
        tgt.loc    = AW'({bank, addr[REG_W-1:0]});
      end
      default: begin
        tgt.is_bit = 1'b1;
        tgt.to_sfr = addr[HI_BIT];
        if (addr[HI_BIT]) begin
          tgt.loc = {addr[AW-1:IW], {IW{1'b0}}};
        end else begin
          tgt.loc = BIT_WIN_BASE + AW'(addr[AW-2:IW]);
        end
      end
    endcase
  end

  logic [WIN_W-1:0] unused_win;
  assign unused_win = '0;
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[addr] <= wdata;
    end
    if (rd_en) begin
      rdata_q <= mem_q[addr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/idata_ctrl.sv
module idata_ctrl
  import idata_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  target_t       tgt,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_bit,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] sfr_rdata,
  output logic          ram_rd_en,
  output logic          ram_wr_en,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] sfr_addr,
  output logic          sfr_we,
  output logic [DW-1:0] sfr_wdata,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  // register state
  logic          busy_q,   busy_d;
  target_t       hold_q,   hold_d;
  logic          hbit_q,   hbit_d;
  logic [DW-1:0] cap_q,    cap_d;
  logic          rv_q,     rv_d;
  logic          rsfr_q,   rsfr_d;
  logic          rbit_q,   rbit_d;
  logic [IW-1:0] ridx_q,   ridx_d;

  logic          accept;
  logic          cap_en;
  logic [DW-1:0] wb_base;
  logic [DW-1:0] merged;
  logic [DW-1:0] rd_base;
  logic [DW-1:0] wr_byte;

  assign accept = req_valid & ~busy_q;
  assign cap_en = accept & tgt.to_sfr;

  // write-back source for the read-modify-write second cycle
  assign wb_base = hold_q.to_sfr ? cap_q : ram_rdata;

  for (genvar b = 0; b < DW; b++) begin : g_merge
    assign merged[b] = (hold_q.idx == IW'(b)) ? hbit_q : wb_base[b];
  end

  assign wr_byte = busy_q ? merged : req_wdata;

  // next-state logic
  always_comb begin
    busy_d = accept & tgt.is_bit & tgt.is_wr;
    hold_d = accept ? tgt : hold_q;
    hbit_d = accept ? req_bit : hbit_q;
    cap_d  = cap_en ? sfr_rdata : cap_q;
    rv_d   = accept & ~tgt.is_wr;
    rsfr_d = accept ? tgt.to_sfr : rsfr_q;
    rbit_d = accept ? tgt.is_bit : rbit_q;
    ridx_d = accept ? tgt.idx : ridx_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= '0;
      hbit_q <= 1'b0;
      cap_q  <= '0;
      rv_q   <= 1'b0;
      rsfr_q <= 1'b0;
      rbit_q <= 1'b0;
      ridx_q <= '0;
    end else begin
      busy_q <= busy_d;
      hold_q <= hold_d;
      hbit_q <= hbit_d;
      cap_q  <= cap_d;
      rv_q   <= rv_d;
      rsfr_q <= rsfr_d;
      rbit_q <= rbit_d;
      ridx_q <= ridx_d;
    end
  end

  // memory and bus drive
  always_comb begin
    ram_rd_en = accept & ~tgt.to_sfr;
    ram_addr  = busy_q ? hold_q.loc : tgt.loc;
    ram_wdata = wr_byte;
    sfr_addr  = busy_q ? hold_q.loc : tgt.loc;
    sfr_wdata = wr_byte;
    if (busy_q) begin
      ram_wr_en = ~hold_q.to_sfr;
      sfr_we    = hold_q.to_sfr;
    end else begin
      ram_wr_en = accept & tgt.is_wr & ~tgt.is_bit & ~tgt.to_sfr;
      sfr_we    = accept & tgt.is_wr & ~tgt.is_bit &  tgt.to_sfr;
    end
  end

  // response
  assign rd_base   = rsfr_q ? cap_q : ram_rdata;
  assign rsp_data  = rbit_q ? {{(DW-1){1'b0}}, rd_base[ridx_q]} : rd_base;
  assign rsp_valid = rv_q;
  assign busy      = busy_q;
endmodule

// File: rtl/idata_unit.sv
module idata_unit
  import idata_pkg::*;
#(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_bit,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic [AW-1:0]     sfr_addr,
  output logic              sfr_we,
  output logic [DW-1:0]     sfr_wdata,
  input  logic [DW-1:0]     sfr_rdata
);
  // asynchronous assert, synchronous release
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  target_t       tgt;
  logic          ram_rd_en;
  logic          ram_wr_en;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;

  idata_decode #(.BANK_W(BANK_W)) u_decode (
    .kind (req_kind),
    .addr (req_addr),
    .bank (bank_sel),
    .tgt  (tgt)
  );

  idata_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rd_en (ram_rd_en),
    .wr_en (ram_wr_en),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  idata_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .req_valid (req_valid),
    .tgt       (tgt),
    .req_wdata (req_wdata),
    .req_bit   (req_bit),
    .ram_rdata (ram_rdata),
    .sfr_rdata (sfr_rdata),
    .ram_rd_en (ram_rd_en),
    .ram_wr_en (ram_wr_en),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .sfr_wdata (sfr_wdata),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/idata_unit_chk.sv
module idata_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic [7:0] req_addr,
  input logic       busy,
  input logic       rsp_valid,
  input logic [7:0] sfr_addr,
  input logic       sfr_we
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!rsp_valid && !busy && !sfr_we);
    end
  end

  // R2 / R10: a response only follows an accepted read
  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !busy && !req_kind[0]));

  assert_direct_sfr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == 3'd1 && req_addr[7]) |-> (sfr_we && sfr_addr == req_addr));

  assert_indirect_no_sfr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind[2:1] == 2'b01) |-> !sfr_we);

  assert_bit_sfr_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sfr_we) |-> (sfr_addr[2:0] == 3'd0));

  assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !$past(busy));

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(req_valid && req_kind == 3'd7));

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rsp_valid);
endmodule

bind idata_unit idata_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_addr  (req_addr),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .sfr_addr  (sfr_addr),
  .sfr_we    (sfr_we)
);

// File: tb/idata_unit_tb_top.sv
`timescale 1ns/1ps
module idata_unit_tb_top;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_kind;
  logic [7:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_bit;
  logic [1:0] bank_sel;
  logic       busy;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic [7:0] sfr_addr;
  logic       sfr_we;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;

  int n_chk;
  int n_fail;

  // behavioural peripheral side: SFRs below 0xC0 exist, the rest read zero
  logic [7:0] sfr_mem [256];
  // reference model
  logic [7:0] exp_ram [256];
  logic [7:0] exp_sfr [256];

  idata_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_bit   (req_bit),
    .bank_sel  (bank_sel),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign sfr_rdata = (sfr_addr < 8'hC0) ? sfr_mem[sfr_addr] : 8'h00;
  always @(posedge clk) begin
    if (sfr_we && sfr_addr < 8'hC0) sfr_mem[sfr_addr] <= sfr_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] k, input logic [7:0] a, input logic [7:0] wd,
                    input logic b, input logic [1:0] bk, input bit stray, input string tag);
    logic wr, bitop, to_sfr;
    int   loc, idx;
    logic [7:0] cur, nxt, exp_rd;
    wr    = k[0];
    bitop = (k[2:1] == 2'd3);
    idx   = a % 8;
    case (k[2:1])
      2'd0:    begin to_sfr = (a >= 128); loc = a; end
      2'd1:    begin to_sfr = 1'b0; loc = a; end
      2'd2:    begin to_sfr = 1'b0; loc = bk * 8 + (a % 8); end
      default: begin to_sfr = (a >= 128); loc = to_sfr ? (a - idx) : (32 + a / 8); end
    endcase
    cur = to_sfr ? ((loc < 192) ? exp_sfr[loc] : 8'h00) : exp_ram[loc];
    nxt = wd;
    if (bitop) begin nxt = cur; nxt[idx] = b; end
    exp_rd = bitop ? {7'b0, cur[idx]} : cur;

    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; req_bit = b; bank_sel = bk;
    #1;
    chk(sfr_we == (!bitop && wr && to_sfr), {tag, " sfr_we in request cycle"}, sfr_we, (!bitop && wr && to_sfr));
    if (!bitop && wr && to_sfr) begin
      chk(sfr_addr == a && sfr_wdata == wd, {tag, " sfr bus addr/data"}, {sfr_addr, sfr_wdata}, {a, wd});
    end
    @(negedge clk);
    if (stray) begin
      req_valid = 1'b1; req_kind = 3'd1; req_addr = 8'h05; req_wdata = 8'hEE; req_bit = 1'b0;
    end else begin
      req_valid = 1'b0;
    end
    chk(rsp_valid == !wr, {tag, " rsp_valid (R10 for writes)"}, rsp_valid, !wr);
    if (!wr) chk(rsp_data == exp_rd, {tag, " read data"}, rsp_data, exp_rd);
    if (wr) begin
      if (to_sfr) begin
        if (loc < 192) exp_sfr[loc] = nxt;
      end else begin
        exp_ram[loc] = nxt;
      end
    end
    if (bitop && wr) begin
      chk(busy == 1'b1, {tag, " R8 busy in write-back cycle"}, busy, 1);
      #1;
      chk(sfr_we == to_sfr, {tag, " R8 write-back strobe"}, sfr_we, to_sfr);
      if (to_sfr) chk(sfr_addr == 8'(loc) && sfr_wdata == nxt, {tag, " R7 write-back addr/byte"},
                      {sfr_addr, sfr_wdata}, {8'(loc), nxt});
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b0, {tag, " R8 busy one cycle only"}, busy, 0);
      chk(rsp_valid == 1'b0, {tag, " R9 no response to ignored request"}, rsp_valid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < 256; i++) begin sfr_mem[i] = 8'h00; exp_sfr[i] = 8'h00; exp_ram[i] = 8'h00; end
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = 8'h00;
    req_wdata = 8'h00; req_bit = 1'b0; bank_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !busy && !sfr_we, "R1 outputs idle in reset", {rsp_valid, busy, sfr_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rsp_valid && !busy && !sfr_we, "R1 outputs idle after release", {rsp_valid, busy, sfr_we}, 0);

    // R4: fill all RAM through indirect writes
    for (int i = 0; i < 256; i++) op(3'd3, 8'(i), 8'(i * 7 + 3), 1'b0, 2'd0, 1'b0, "R4 fill");
    op(3'd2, 8'h80, 8'h00, 1'b0, 2'd0, 1'b0, "R4 indirect upper 0x80");
    op(3'd2, 8'hFF, 8'h00, 1'b0, 2'd0, 1'b0, "R4 indirect upper 0xFF");
    op(3'd2, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, "R4 indirect 0x00");

    // R2: direct lower half
    op(3'd0, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, "R2 direct read 0x00");
    op(3'd0, 8'h7F, 8'h00, 1'b0, 2'd0, 1'b0, "R2 direct read 0x7F");
    op(3'd1, 8'h40, 8'h5A, 1'b0, 2'd0, 1'b0, "R2 direct write 0x40");
    op(3'd0, 8'h40, 8'h00, 1'b0, 2'd0, 1'b0, "R2 direct readback 0x40");

    // R3: direct upper half goes to SFR bus
    op(3'd1, 8'h90, 8'hA5, 1'b0, 2'd0, 1'b0, "R3 direct SFR write 0x90");
    op(3'd0, 8'h90, 8'h00, 1'b0, 2'd0, 1'b0, "R3 direct SFR read 0x90");
    op(3'd0, 8'hC8, 8'h00, 1'b0, 2'd0, 1'b0, "R3 unimplemented SFR reads zero");
    op(3'd2, 8'h90, 8'h00, 1'b0, 2'd0, 1'b0, "R3 RAM 0x90 untouched by SFR write");
    op(3'd3, 8'hA0, 8'h3C, 1'b0, 2'd0, 1'b0, "R4 indirect write 0xA0");
    op(3'd0, 8'hA0, 8'h00, 1'b0, 2'd0, 1'b0, "R4 SFR 0xA0 untouched by indirect write");

    // R5: register banks, upper address bits ignored
    for (int bk = 0; bk < 4; bk++) begin
      op(3'd5, 8'hF5, 8'(8'h10 + bk), 1'b0, 2'(bk), 1'b0, "R5 register write");
    end
    for (int bk = 0; bk < 4; bk++) begin
      op(3'd2, 8'(bk * 8 + 5), 8'h00, 1'b0, 2'd0, 1'b0, "R5 register location via indirect");
      op(3'd4, 8'h0D, 8'h00, 1'b0, 2'(bk), 1'b0, "R5 register read");
    end

    // R6 / R8: RAM bit window
    op(3'd1, 8'h20, 8'h00, 1'b0, 2'd0, 1'b0, "R6 clear 0x20");
    op(3'd1, 8'h2F, 8'hFF, 1'b0, 2'd0, 1'b0, "R6 set 0x2F");
    op(3'd7, 8'h00, 8'h00, 1'b1, 2'd0, 1'b0, "R6 bit write 0x00");
    op(3'd7, 8'h7F, 8'h00, 1'b0, 2'd0, 1'b0, "R6 bit write 0x7F");
    op(3'd0, 8'h20, 8'h00, 1'b0, 2'd0, 1'b0, "R8 other bits of 0x20 unchanged");
    op(3'd0, 8'h2F, 8'h00, 1'b0, 2'd0, 1'b0, "R8 other bits of 0x2F unchanged");
    op(3'd6, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, "R6 bit read 0x00");
    op(3'd6, 8'h7E, 8'h00, 1'b0, 2'd0, 1'b0, "R6 bit read 0x7E");
    op(3'd7, 8'h2B, 8'h00, 1'b1, 2'd0, 1'b0, "R6 bit write mid window");
    op(3'd6, 8'h2B, 8'h00, 1'b0, 2'd0, 1'b0, "R6 bit read back mid window");

    // R7: SFR bits only at multiples of eight; neighbours untouched
    for (int i = 0; i < 8; i++) op(3'd1, 8'(8'h80 + i), 8'(8'h11 * i + 8'h22), 1'b0, 2'd0, 1'b0, "R7 preload SFR");
    op(3'd7, 8'h83, 8'h00, 1'b1, 2'd0, 1'b0, "R7 bit write 0x83");
    op(3'd7, 8'h86, 8'h00, 1'b0, 2'd0, 1'b0, "R7 bit write 0x86");
    for (int i = 0; i < 8; i++) op(3'd0, 8'(8'h80 + i), 8'h00, 1'b0, 2'd0, 1'b0, "R7 SFR readback");
    op(3'd6, 8'h83, 8'h00, 1'b0, 2'd0, 1'b0, "R7 SFR bit read 0x83");
    op(3'd6, 8'h91, 8'h00, 1'b0, 2'd0, 1'b0, "R7 SFR bit read 0x91");
    op(3'd7, 8'hCA, 8'h00, 1'b1, 2'd0, 1'b0, "R7 bit write unimplemented SFR");

    // R9: request during write-back cycle is ignored
    op(3'd7, 8'h10, 8'h00, 1'b1, 2'd0, 1'b1, "R9 bit write with stray request");
    op(3'd0, 8'h05, 8'h00, 1'b0, 2'd0, 1'b0, "R9 stray write had no effect");
    op(3'd0, 8'h22, 8'h00, 1'b0, 2'd0, 1'b0, "R8 byte after bit write");
    op(3'd7, 8'h94, 8'h00, 1'b0, 2'd0, 1'b1, "R9 SFR bit write with stray request");
    op(3'd0, 8'h90, 8'h00, 1'b0, 2'd0, 1'b0, "R9 SFR 0x90 after merge");
    op(3'd0, 8'h05, 8'h00, 1'b0, 2'd0, 1'b0, "R9 stray write still absent");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule